// File: doc/BRIEF.md
# Runtime-Configurable Clock Divider

This block produces a slow, clock-like square wave from a fast input clock. The division ratio is not fixed at build time: it is an unsigned integer presented on an input port and sampled on every rising edge. Software or a neighbouring block can therefore change the output frequency while the divider runs. A ratio change takes effect on the next edge, without a reset.

For any ratio of two or more, a single counter measures how long the output has stayed at its current level. When the counter reaches the end of the high or low phase, the output flips and the counter goes back to zero. Even ratios give equal halves. Odd ratios give a high phase one cycle shorter than the low phase, so the period is still exactly the ratio. Two ratio values do not divide. A ratio of zero holds the output low and a ratio of one holds it high, which gives a simple stop or force control.

The output comes straight from a flip-flop. It suits enable-style or low-speed timing use. It must not be used as a glitch-free clock mux.

Top module: `clk_ratio_div`

## Requirements
- R1: The ratio input is sampled on every rising edge. A changed ratio governs the very next phase decision, with no reset needed.
- R2: While the ratio is 0, the output is low from the cycle after that ratio is sampled.
- R3: While the ratio is 1, the output is high from the cycle after that ratio is sampled.
- R4: For a steady even ratio N of at least 2, the output stays high for N/2 cycles and low for N/2 cycles.
- R5: For a steady odd ratio N of at least 3, the output stays high for floor(N/2) cycles and low for N - floor(N/2) cycles, so the period is N.
- R6: After reset is released with a ratio N of at least 2, the output starts low and stays low for N - floor(N/2) cycles before it first rises.
- R7: The phase counter is zero whenever the output has just changed level. If the ratio shrinks so that the count already meets or passes the new phase length, the output flips on the next edge and counting restarts from zero.
- R8: A synchronous, active-high reset drives the output low and clears the counter on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ratio | input | W (32) | Unsigned division ratio; 0 = hold low, 1 = hold high |
| clk_out | output | 1 | Divided output, driven from a flip-flop |

## Verification
The bench goes after odd ratios. A design that split the period evenly would give the wrong high and low lengths, or a period one cycle off. It also shrinks the ratio in the middle of a long phase. A design that only restarted on an exact match would run through most of its 32-bit count and hold the output for billions of cycles. It also checks the all-ones ratio, where an overflow in the half-period arithmetic would produce short phases. Finally, it switches between the hold values 0 and 1 and real ratios, in both directions. This exposes a swapped hold polarity, or a counter left stale when division resumes.

// File: rtl/clk_ratio_div.sv
module clk_ratio_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ratio,
  output logic         clk_out
);

  logic [W-1:0] cnt;
  logic [W-1:0] hi_len, lo_len, term;
  logic         hold_lo, hold_hi, at_end;

  assign hold_lo = (ratio == '0);
  assign hold_hi = (ratio == W'(1));
  assign hi_len  = ratio >> 1;
  assign lo_len  = ratio - hi_len;
  assign term    = clk_out ? hi_len - W'(1) : lo_len - W'(1);
  assign at_end  = (cnt >= term);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      clk_out <= 1'b0;
    end else if (hold_lo) begin
      cnt     <= '0;
      clk_out <= 1'b0;
    end else if (hold_hi) begin
      cnt     <= '0;
      clk_out <= 1'b1;
    end else if (at_end) begin
      cnt     <= '0;
      clk_out <= ~clk_out;
    end else begin
      cnt     <= cnt + W'(1);
    end
  end

endmodule

// File: rtl/clk_ratio_div_chk.sv
module clk_ratio_div_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] ratio,
  input logic         clk_out,
  input logic [W-1:0] cnt
);

  a_r8_reset_low: assert property (@(posedge clk)
    rst |=> (!clk_out && cnt == '0));

  a_r2_zero_low: assert property (@(posedge clk) disable iff (rst)
    (ratio == '0) |=> !clk_out);

  a_r3_one_high: assert property (@(posedge clk) disable iff (rst)
    (ratio == W'(1)) |=> clk_out);

  a_r7_toggle_restarts: assert property (@(posedge clk) disable iff (rst)
    (clk_out != $past(clk_out)) |-> (cnt == '0));

  a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
    (ratio >= W'(2) && ratio == $past(ratio)) |-> (cnt < ratio));

endmodule

bind clk_ratio_div clk_ratio_div_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ratio(ratio), .clk_out(clk_out), .cnt(cnt)
);

// File: tb/clk_ratio_div_bench.sv
module clk_ratio_div_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [31:0] ratio;
  logic        clk_out;

  clk_ratio_div #(.W(32)) u_clk_ratio_div (
    .clk(clk), .rst(rst), .ratio(ratio), .clk_out(clk_out)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic        exp_lvl;
  logic [32:0] exp_run;
  logic [31:0] prv;
  int          since_rst = 0, since_chg = 0;
  bit          grew = 0;

  function automatic logic [32:0] phase_len(logic [31:0] n, logic lvl);
    logic [32:0] h;
    h = {1'b0, n >> 1};
    return lvl ? h : ({1'b0, n} - h);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (ratio != prv) begin
      grew = (ratio > prv);
      since_chg = 0;
    end else since_chg++;
    prv = ratio;
    if (rst) begin
      exp_lvl = 1'b0; exp_run = '0; since_rst = 0;
    end else begin
      since_rst++;
      if (ratio == 0) begin exp_lvl = 1'b0; exp_run = '0; end
      else if (ratio == 1) begin exp_lvl = 1'b1; exp_run = '0; end
      else if (exp_run + 33'd1 >= phase_len(ratio, exp_lvl)) begin
        exp_lvl = ~exp_lvl; exp_run = '0;
      end else exp_run = exp_run + 33'd1;
    end
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected finish before 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic string tag();
    if (rst) return "R8";
    if (ratio == 0) return "R2";
    if (ratio == 1) return "R3";
    if (since_rst <= int'(ratio)) return "R6";
    if (since_chg <= int'(ratio)) return grew ? "R1" : "R7";
    return ratio[0] ? "R5" : "R4";
  endfunction

  always @(negedge clk) begin
    if (!done && cyc > 0) begin
      checks++;
      if (clk_out !== exp_lvl) begin
        errors++;
        $display("FAIL %s: clk_out=%0b expected %0b (ratio=%0d)",
                 tag(), clk_out, exp_lvl, ratio);
      end
    end
  end

  task automatic seg(logic [31:0] n, logic r, int len);
    @(negedge clk);
    #1;
    ratio = n;
    rst = r;
    repeat (len) @(posedge clk);
  endtask

  initial begin
    int unsigned seed;
    rst = 1'b1; ratio = 32'd6; prv = 32'd6;
    seed = $urandom(32'd20240611);
    seg(32'd6, 1'b1, 3);
    seg(32'd6, 1'b0, 40);
    seg(32'd7, 1'b0, 40);
    seg(32'd2, 1'b0, 20);
    seg(32'd3, 1'b0, 20);
    seg(32'd0, 1'b0, 10);
    seg(32'd1, 1'b0, 10);
    seg(32'd0, 1'b0, 5);
    seg(32'd5, 1'b0, 30);
    seg(32'd100, 1'b0, 35);
    seg(32'd4, 1'b0, 20);
    seg(32'hFFFF_FFFF, 1'b0, 200);
    seg(32'd9, 1'b0, 5);
    seg(32'd9, 1'b1, 2);
    seg(32'd9, 1'b0, 40);
    for (int i = 0; i < 250; i++) begin
      int k;
      logic [31:0] n;
      k = $urandom_range(0, 9);
      if (k == 0) n = 32'd0;
      else if (k == 1) n = 32'd1;
      else if (k == 2) n = $urandom_range(100, 400);
      else n = $urandom_range(2, 24);
      seg(n, ($urandom_range(0, 15) == 0), $urandom_range(5, 120));
    end
    seg(32'd8, 1'b0, 20);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule